// File: doc/BRIEF.md
# Masked Quadword-to-Byte Vector Narrower

This block narrows a vector of 64-bit lanes into packed bytes. Each lane gives one byte. An opcode byte picks how the byte is formed: by truncation, by signed saturation or by unsigned saturation. Lane `j` fills result byte `j`, so the packed bytes start at the least-significant end of the 128-bit result. A vector-length select sets how many lanes take part.

A per-lane mask decides which bytes are computed. The mask can be turned off entirely. The destination can be a register or memory:

- **Register destination:** a masked-off byte either keeps its old value or becomes zero, and every byte above the active length is cleared.
- **Memory destination:** only merging applies. Per-byte write enables mark the bytes that must be stored.

A register-specifier field other than all-ones, or an opcode that is not one of the three narrowing codes, raises an undefined-opcode fault. A faulting operation writes nothing. Each accepted operation produces a registered result one cycle later.

Top module: `qbn_narrow_unit`

## Requirements
- R1: Opcode 0x32 selects truncation: the byte for a lane is bits [7:0] of that lane.
- R2: Opcode 0x22 selects signed saturation: a lane above 127 gives 0x7F, a lane below -128 gives 0x80, and any other lane gives its low byte.
- R3: Opcode 0x12 selects unsigned saturation: a lane above 255 gives 0xFF, and any other lane gives its low byte.
- R4: `vlen_sel` sets the number of active lanes: 0 gives 2 lanes, 1 gives 4 lanes, and 2 or 3 gives 8 lanes. Lane `j` reads `src_vec[64j+63:64j]` and drives `result[8j+7:8j]`.
- R5: A lane is computed when its `lane_mask` bit is 1 or when `no_mask` is 1.
- R6: With a register destination (`mem_dest`=0), an active lane that is not computed keeps `old_dest[8j+7:8j]` when `zero_mode`=0 and gives 0x00 when `zero_mode`=1.
- R7: With a register destination, every result byte at or above the active lane count is 0, up to bit 127, and `byte_we` is all zero.
- R8: With a memory destination (`mem_dest`=1), `byte_we[j]` is 1 only for computed active lanes. Active lanes that are not computed carry `old_dest` bytes whatever `zero_mode` is. Bytes above the active length are 0 with their enable at 0.
- R9: If `reg_spec` is not 4'b1111, or the opcode is none of 0x32, 0x22 and 0x12, then `ud_fault` is 1, `byte_we` is 0 and `result` is 0.
- R10: Results, enables and the fault flag appear one cycle after `in_valid`, with `out_valid` set in that cycle only. A synchronous active-high reset clears `out_valid`, `result`, `byte_we` and `ud_fault`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation present this cycle |
| src_vec | input | 512 | Source lanes, 64 bits each |
| opcode | input | 8 | Narrowing code (0x32, 0x22, 0x12) |
| lane_mask | input | 8 | Per-lane write mask |
| no_mask | input | 1 | Ignore the mask; compute every active lane |
| vlen_sel | input | 2 | Vector length: 0=128, 1=256, 2/3=512 bits |
| zero_mode | input | 1 | Zero (1) or merge (0) masked lanes, register form |
| mem_dest | input | 1 | Destination is memory (1) or register (0) |
| old_dest | input | 128 | Previous destination contents |
| reg_spec | input | 4 | Register-specifier field, must be 4'b1111 |
| out_valid | output | 1 | Result valid |
| result | output | 128 | Packed narrowed bytes |
| byte_we | output | 16 | Per-byte store enables, memory form |
| ud_fault | output | 1 | Undefined-opcode fault |

## Verification
The bench builds the unit with its default parameters: eight 64-bit lanes, 8-bit bytes and a 128-bit destination. With these values all three vector lengths can be reached, so both the upper-byte clearing at 2 and 4 lanes and the full 8-lane memory enables are exercised. Lanes are driven near every saturation edge (127/128, -128/-129, 255/256 and the 64-bit extremes), under merge, zero and memory forms, with random masks and occasional faulting encodings.

// File: rtl/qbn_pkg.sv
package qbn_pkg;

    localparam logic [7:0] OP_TRUNC = 8'h32;
    localparam logic [7:0] OP_SSAT  = 8'h22;
    localparam logic [7:0] OP_USAT  = 8'h12;
    localparam logic [3:0] SPEC_OK  = 4'hF;

    typedef enum logic [1:0] {
        NM_TRUNC = 2'd0,
        NM_SSAT  = 2'd1,
        NM_USAT  = 2'd2,
        NM_BAD   = 2'd3
    } narrow_mode_e;

    typedef struct packed {
        logic         illegal;
        narrow_mode_e mode;
    } op_dec_t;

    function automatic narrow_mode_e mode_of(input logic [7:0] op);
        case (op)
            OP_TRUNC: return NM_TRUNC;
            OP_SSAT:  return NM_SSAT;
            OP_USAT:  return NM_USAT;
            default:  return NM_BAD;
        endcase
    endfunction

endpackage

// File: rtl/qbn_decode.sv
module qbn_decode
    import qbn_pkg::*;
#(
    parameter int LANES = 8
) (
    input  logic [7:0]       opcode,
    input  logic [3:0]       reg_spec,
    input  logic [1:0]       vlen_sel,
    output op_dec_t          dec,
    output logic [LANES-1:0] active
);
    narrow_mode_e mode_w;

    always_comb begin
        mode_w      = mode_of(opcode);
        dec.mode    = mode_w;
        dec.illegal = (reg_spec != SPEC_OK) || (mode_w == NM_BAD);
    end

    // lane j is active when j is below 2, 4 or 8 lanes
    for (genvar j = 0; j < LANES; j++) begin : g_act
        localparam bit IN2 = (j < 2);
        localparam bit IN4 = (j < 4);
        assign active[j] = (vlen_sel == 2'd0) ? IN2 :
                           (vlen_sel == 2'd1) ? IN4 : 1'b1;
    end
endmodule

// File: rtl/qbn_lane.sv
module qbn_lane
    import qbn_pkg::*;
#(
    parameter int LANE_W = 64,
    parameter int BYTE_W = 8
) (
    input  logic [LANE_W-1:0] lane,
    input  narrow_mode_e      mode,
    output logic [BYTE_W-1:0] byte_out
);
    localparam logic [BYTE_W-1:0] SMAX = {1'b0, {(BYTE_W-1){1'b1}}};
    localparam logic [BYTE_W-1:0] SMIN = {1'b1, {(BYTE_W-1){1'b0}}};
    localparam logic [BYTE_W-1:0] UMAX = {BYTE_W{1'b1}};

    logic [LANE_W-BYTE_W:0] sign_run;   // bits LANE_W-1 .. BYTE_W-1
    logic                   s_fits;
    logic                   u_fits;

    always_comb begin
        sign_run = lane[LANE_W-1:BYTE_W-1];
        s_fits   = (&sign_run) || !(|sign_run);
        u_fits   = !(|lane[LANE_W-1:BYTE_W]);
        case (mode)
            NM_SSAT:  byte_out = s_fits ? lane[BYTE_W-1:0] :
                                 (lane[LANE_W-1] ? SMIN : SMAX);
            NM_USAT:  byte_out = u_fits ? lane[BYTE_W-1:0] : UMAX;
            default:  byte_out = lane[BYTE_W-1:0];
        endcase
    end
endmodule

// File: rtl/qbn_byte_merge.sv
module qbn_byte_merge #(
    parameter int BYTE_W = 8
) (
    input  logic              illegal,
    input  logic              active,
    input  logic              computed,
    input  logic              zero_mode,
    input  logic              mem_dest,
    input  logic [BYTE_W-1:0] new_byte,
    input  logic [BYTE_W-1:0] old_byte,
    output logic [BYTE_W-1:0] byte_out,
    output logic              we
);
    always_comb begin
        byte_out = '0;
        we       = 1'b0;
        if (!illegal && active) begin
            if (computed) begin
                byte_out = new_byte;
                we       = mem_dest;
            end else if (mem_dest || !zero_mode) begin
                byte_out = old_byte;
            end
        end
    end
endmodule

// File: rtl/qbn_narrow_unit.sv
module qbn_narrow_unit
    import qbn_pkg::*;
#(
    parameter int LANES  = 8,
    parameter int LANE_W = 64,
    parameter int BYTE_W = 8,
    parameter int DST_W  = 128
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      in_valid,
    input  logic [LANES*LANE_W-1:0]   src_vec,
    input  logic [7:0]                opcode,
    input  logic [LANES-1:0]          lane_mask,
    input  logic                      no_mask,
    input  logic [1:0]                vlen_sel,
    input  logic                      zero_mode,
    input  logic                      mem_dest,
    input  logic [DST_W-1:0]          old_dest,
    input  logic [3:0]                reg_spec,
    output logic                      out_valid,
    output logic [DST_W-1:0]          result,
    output logic [DST_W/BYTE_W-1:0]   byte_we,
    output logic                      ud_fault
);
    localparam int DST_BYTES = DST_W / BYTE_W;

    op_dec_t                dec;
    logic [LANES-1:0]       active;
    logic [DST_W-1:0]       res_d;
    logic [DST_BYTES-1:0]   we_d;

    qbn_decode #(.LANES(LANES)) u_dec (
        .opcode   (opcode),
        .reg_spec (reg_spec),
        .vlen_sel (vlen_sel),
        .dec      (dec),
        .active   (active)
    );

    for (genvar j = 0; j < DST_BYTES; j++) begin : g_byte
        if (j < LANES) begin : g_lane
            logic [BYTE_W-1:0] nb;
            qbn_lane #(.LANE_W(LANE_W), .BYTE_W(BYTE_W)) u_lane (
                .lane     (src_vec[j*LANE_W +: LANE_W]),
                .mode     (dec.mode),
                .byte_out (nb)
            );
            qbn_byte_merge #(.BYTE_W(BYTE_W)) u_merge (
                .illegal   (dec.illegal),
                .active    (active[j]),
                .computed  (no_mask || lane_mask[j]),
                .zero_mode (zero_mode),
                .mem_dest  (mem_dest),
                .new_byte  (nb),
                .old_byte  (old_dest[j*BYTE_W +: BYTE_W]),
                .byte_out  (res_d[j*BYTE_W +: BYTE_W]),
                .we        (we_d[j])
            );
        end else begin : g_pad
            assign res_d[j*BYTE_W +: BYTE_W] = '0;
            assign we_d[j]                   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
            byte_we   <= '0;
            ud_fault  <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result   <= res_d;
                byte_we  <= we_d;
                ud_fault <= dec.illegal;
            end
        end
    end

    // R10
    latency_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    // R10
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);
    // R9
    fault_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && reg_spec != SPEC_OK) |=> (ud_fault && byte_we == '0 && result == '0));
    // R7
    reg_no_we_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !mem_dest) |=> (byte_we == '0));
    // R7
    short_upper_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && vlen_sel == 2'd0) |=>
            (result[DST_W-1:2*BYTE_W] == '0 && byte_we[DST_BYTES-1:2] == '0));
    // R8
    mem_full_we_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mem_dest && no_mask && vlen_sel == 2'd0 &&
         reg_spec == SPEC_OK && opcode == OP_TRUNC) |=> (byte_we[1:0] == 2'b11));
endmodule

// File: tb/qbn_narrow_unit_test.sv
module qbn_narrow_unit_test;
    localparam int PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [511:0] src_vec = '0;
    logic [7:0]   opcode = 8'h32;
    logic [7:0]   lane_mask = '0;
    logic         no_mask = 1'b0;
    logic [1:0]   vlen_sel = '0;
    logic         zero_mode = 1'b0;
    logic         mem_dest = 1'b0;
    logic [127:0] old_dest = '0;
    logic [3:0]   reg_spec = 4'hF;
    logic         out_valid;
    logic [127:0] result;
    logic [15:0]  byte_we;
    logic         ud_fault;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    bit           q_vld[$];
    logic [127:0] q_res[$];
    logic [15:0]  q_we[$];
    bit           q_flt[$];
    string        q_tag[$];

    always #(PERIOD/2) clk = ~clk;

    qbn_narrow_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .src_vec(src_vec),
        .opcode(opcode), .lane_mask(lane_mask), .no_mask(no_mask),
        .vlen_sel(vlen_sel), .zero_mode(zero_mode), .mem_dest(mem_dest),
        .old_dest(old_dest), .reg_spec(reg_spec), .out_valid(out_valid),
        .result(result), .byte_we(byte_we), .ud_fault(ud_fault)
    );

    task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic void ref_model(
        input logic [511:0] s, input logic [7:0] op, input logic [7:0] m,
        input bit nm, input logic [1:0] vs, input bit z, input bit md,
        input logic [127:0] old, input logic [3:0] spec,
        output logic [127:0] r, output logic [15:0] w, output bit f);
        int kl;
        r = '0; w = '0;
        f = (spec != 4'hF) || !(op == 8'h32 || op == 8'h22 || op == 8'h12);
        if (f) return;
        kl = (vs == 2'd0) ? 2 : (vs == 2'd1) ? 4 : 8;
        for (int j = 0; j < kl; j++) begin
            logic [63:0] ln;
            longint      sv;
            logic [7:0]  b;
            ln = s[64*j +: 64];
            sv = longint'(ln);
            if (op == 8'h22)      b = (sv > 127) ? 8'h7F : (sv < -128) ? 8'h80 : ln[7:0];
            else if (op == 8'h12) b = (ln > 64'd255) ? 8'hFF : ln[7:0];
            else                  b = ln[7:0];
            if (nm || m[j]) begin
                r[8*j +: 8] = b;
                w[j] = md;
            end else if (md || !z) begin
                r[8*j +: 8] = old[8*j +: 8];
            end
        end
    endfunction

    task automatic check_pending();
        if (q_vld.size() > 0) begin
            bit v; logic [127:0] r; logic [15:0] w; bit f; string t;
            v = q_vld.pop_front(); r = q_res.pop_front(); w = q_we.pop_front();
            f = q_flt.pop_front(); t = q_tag.pop_front();
            check({t, " R10 valid"}, 128'(out_valid), 128'(v));
            if (v) begin
                check({t, " result"}, result, r);
                check({t, " byte_we"}, 128'(byte_we), 128'(w));
                check({t, " R9 fault"}, 128'(ud_fault), 128'(f));
            end
        end
    endtask

    task automatic apply(bit v, logic [511:0] s, logic [7:0] op, logic [7:0] m,
                         bit nm, logic [1:0] vs, bit z, bit md,
                         logic [127:0] old, logic [3:0] spec, string tag);
        logic [127:0] r; logic [15:0] w; bit f;
        @(negedge clk);
        check_pending();
        in_valid = v; src_vec = s; opcode = op; lane_mask = m; no_mask = nm;
        vlen_sel = vs; zero_mode = z; mem_dest = md; old_dest = old; reg_spec = spec;
        ref_model(s, op, m, nm, vs, z, md, old, spec, r, w, f);
        q_vld.push_back(v); q_res.push_back(r); q_we.push_back(w);
        q_flt.push_back(f); q_tag.push_back(tag);
    endtask

    function automatic logic [63:0] pick_lane();
        case ($urandom % 10)
            0: return 64'd127;
            1: return 64'd128;
            2: return 64'hFFFF_FFFF_FFFF_FF80;
            3: return 64'hFFFF_FFFF_FFFF_FF7F;
            4: return 64'd255;
            5: return 64'd256;
            6: return 64'h8000_0000_0000_0000;
            7: return 64'h7FFF_FFFF_FFFF_FFFF;
            8: return 64'($urandom % 512) - 64'd256;
            default: return {$urandom, $urandom};
        endcase
    endfunction

    function automatic logic [511:0] pick_vec();
        logic [511:0] v;
        for (int j = 0; j < 8; j++) v[64*j +: 64] = pick_lane();
        return v;
    endfunction

    initial begin
        #(PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [511:0] edge_s, edge_u, seq_v;
        logic [127:0] old_pat;
        edge_s = {64'h8000_0000_0000_0000, 64'h7FFF_FFFF_FFFF_FFFF,
                  64'hFFFF_FFFF_FFFF_FF7F, 64'hFFFF_FFFF_FFFF_FF80,
                  64'd128, 64'd127, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0};
        edge_u = {64'hFFFF_FFFF_FFFF_FFFF, 64'd256, 64'd255, 64'd0,
                  64'h1_0000_0042, 64'd17, 64'h8000_0000_0000_0001, 64'd200};
        for (int j = 0; j < 8; j++) seq_v[64*j +: 64] = 64'h1234_5600_0000_0000 | 64'(8'hA0 + j);
        old_pat = 128'hEEDD_CCBB_AA99_8877_6655_4433_2211_0F1E;

        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 reset out_valid", 128'(out_valid), 128'd0);
        check("R10 reset result", result, 128'd0);
        check("R10 reset byte_we", 128'(byte_we), 128'd0);
        check("R10 reset ud_fault", 128'(ud_fault), 128'd0);
        rst = 1'b0;

        apply(1, seq_v,  8'h32, 8'h00, 1, 2'd2, 0, 0, old_pat, 4'hF, "R1 trunc R4 lane order");
        apply(1, edge_s, 8'h22, 8'h00, 1, 2'd2, 0, 0, old_pat, 4'hF, "R2 signed edges");
        apply(1, edge_u, 8'h12, 8'h00, 1, 2'd3, 0, 0, old_pat, 4'hF, "R3 unsigned edges");
        apply(1, edge_u, 8'h22, 8'h00, 1, 2'd1, 0, 0, old_pat, 4'hF, "R4 R7 four lanes");
        apply(1, edge_s, 8'h12, 8'h00, 1, 2'd0, 0, 0, old_pat, 4'hF, "R4 R7 two lanes");
        apply(0, seq_v,  8'h32, 8'h00, 1, 2'd2, 0, 0, old_pat, 4'hF, "R10 idle");
        apply(1, seq_v,  8'h32, 8'hA5, 0, 2'd2, 0, 0, old_pat, 4'hF, "R5 R6 merge");
        apply(1, seq_v,  8'h32, 8'hA5, 0, 2'd2, 1, 0, old_pat, 4'hF, "R5 R6 zero");
        apply(1, seq_v,  8'h22, 8'h00, 0, 2'd1, 1, 0, old_pat, 4'hF, "R6 all masked zero");
        apply(1, seq_v,  8'h32, 8'h5A, 0, 2'd2, 1, 1, old_pat, 4'hF, "R8 mem zero ignored");
        apply(1, edge_u, 8'h12, 8'hFF, 0, 2'd1, 0, 1, old_pat, 4'hF, "R8 mem four lanes");
        apply(1, seq_v,  8'h32, 8'h00, 1, 2'd0, 0, 1, old_pat, 4'hF, "R8 mem two lanes");
        apply(1, seq_v,  8'h32, 8'hFF, 1, 2'd2, 0, 1, old_pat, 4'hE, "R9 bad spec");
        apply(1, seq_v,  8'h33, 8'hFF, 1, 2'd2, 0, 0, old_pat, 4'hF, "R9 bad opcode");
        apply(1, seq_v,  8'h32, 8'h0F, 0, 2'd2, 0, 1, old_pat, 4'hF, "R10 back to back");

        for (int n = 0; n < 400; n++) begin
            logic [7:0] op;
            case ($urandom % 8)
                0, 1, 2: op = 8'h22;
                3, 4:    op = 8'h12;
                5, 6:    op = 8'h32;
                default: op = 8'($urandom);
            endcase
            apply(($urandom % 5) != 0, pick_vec(), op, 8'($urandom), ($urandom % 4) == 0,
                  2'($urandom), 1'($urandom), 1'($urandom), {$urandom, $urandom, $urandom, $urandom},
                  (($urandom % 10) == 0) ? 4'($urandom) : 4'hF, "R1 R2 R3 R5 R6 R8 random");
        end
        apply(0, '0, 8'h32, 8'h00, 0, 2'd0, 0, 0, '0, 4'hF, "R10 flush");
        @(negedge clk);
        check_pending();

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule